// File: doc/BRIEF.md
# Coprocessor Pipeline Follower

This block sits beside a host processor and mirrors the host's pipeline so that coprocessor load and store instructions can move a variable number of words. An active-low advance strobe from the host drives a two-stage shadow pipeline. On each advance, the word on the instruction bus is classified into a Decode stage, and whatever Decode held moves on into Execute.

Decode answers the host on one 2-bit handshake bus. Execute answers on a second 2-bit bus and counts the words of the transfer. The coprocessor sets the transfer length entirely through the responses it gives: GO for every word except the final one, which gets LAST.

The host's pass signal confirms during the first Execute cycle that the instruction really runs. A late-cancel input abandons the instruction that is currently in Execute.

Top module: `cop_follower`

## Requirements
- R1: After a cycle with `rst` high, both `dec_resp` and `exe_resp` read ABSENT. The handshake encoding is 00 ABSENT, 01 WAIT, 10 GO, 11 LAST.
- R2: After an edge with `adv_n` low and `cancel` low, `dec_resp` is GO when the captured word has bits [27:25] equal to 110 and bits [11:8] equal to `cp_id`. Otherwise it is ABSENT.
- R3: After an edge with `adv_n` high, `dec_resp` keeps its value whatever the instruction bus carries.
- R4: An advance moves the Decode entry into Execute. After that edge, `exe_resp` is GO, or LAST if `xfer_len` is 0, when Decode held a match. It is ABSENT when Decode held no match.
- R5: A length field of L moves L+1 words. `exe_resp` shows GO for L consecutive cycles and then LAST for one cycle, with no advance in between.
- R6: After a cycle showing LAST with no advance and no cancel, `exe_resp` returns to ABSENT and stays there until the next advance.
- R7: If `pass` is low in the first Execute cycle of an instruction, `exe_resp` is ABSENT from the next cycle on for that instruction.
- R8: `pass` has no effect after the first Execute cycle: the GO/LAST sequence runs to its end.
- R9: `cancel` high makes `exe_resp` ABSENT after the next edge and clears the word count. A later instruction therefore runs its full length.
- R10: `cancel` takes priority over an advance in the same cycle: the Decode stage and `dec_resp` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| adv_n | input | 1 | Host pipeline-advance strobe, active low |
| instr | input | 32 | Instruction bus from the host fetch |
| cp_id | input | 4 | Coprocessor number this block answers to |
| xfer_len | input | 4 | Words to move minus one (0 gives 1 word, 15 gives 16) |
| pass | input | 1 | Host confirms the Execute instruction runs |
| cancel | input | 1 | Late cancel of the Execute stage |
| dec_resp | output | 2 | Decode-stage handshake response |
| exe_resp | output | 2 | Execute-stage handshake response |

## Verification
The assertions assume the host holds `adv_n` high while a GO/LAST sequence runs. They also assume `xfer_len` and `cp_id` stay constant from the advance that starts an instruction until its LAST. The stimulus honours both assumptions: it sets the length and identity before the advance that starts each instruction, and it issues an advance only after ABSENT has been seen again or after a deliberate cancel or drop.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
  typedef enum logic [1:0] {
    RSP_ABSENT = 2'b00,
    RSP_WAIT   = 2'b01,
    RSP_GO     = 2'b10,
    RSP_LAST   = 2'b11
  } rsp_e;
endpackage

// File: rtl/cpf_decode.sv
module cpf_decode
  import cpf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ID_W    = 4,
  parameter int ID_LSB  = 8,
  parameter int CLS_W   = 3,
  parameter int CLS_LSB = 25,
  parameter int CLS_VAL = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              hold,
  input  logic [DATA_W-1:0] instr,
  input  logic [ID_W-1:0]   cp_id,
  output logic              match_q,
  output rsp_e              resp_q
);
  localparam logic [DATA_W-1:0] CLS_MASK = DATA_W'(((1 << CLS_W) - 1)) << CLS_LSB;
  localparam logic [DATA_W-1:0] ID_MASK  = DATA_W'(((1 << ID_W) - 1)) << ID_LSB;
  localparam logic [DATA_W-1:0] CLS_PAT  = DATA_W'(CLS_VAL) << CLS_LSB;

  logic [DATA_W-1:0] pattern;
  logic              hit;

  // Mask-compare uses the whole word: class field plus coprocessor number.
  always_comb begin
    pattern = CLS_PAT | (DATA_W'(cp_id) << ID_LSB);
    hit     = ((instr & (CLS_MASK | ID_MASK)) == pattern);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      resp_q  <= RSP_ABSENT;
    end else if (adv && !hold) begin
      match_q <= hit;
      resp_q  <= hit ? RSP_GO : RSP_ABSENT;
    end
  end
endmodule

// File: rtl/cpf_execute.sv
module cpf_execute
  import cpf_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             cancel,
  input  logic             pass,
  input  logic             dec_match,
  input  logic [LEN_W-1:0] len,
  output rsp_e             resp_q
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_nxt;
  logic             first_q;

  always_comb cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      resp_q  <= RSP_ABSENT;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else if (adv) begin
      cnt_q   <= '0;
      first_q <= dec_match;
      if (dec_match) resp_q <= (len == '0) ? RSP_LAST : RSP_GO;
      else           resp_q <= RSP_ABSENT;
    end else if (first_q && !pass) begin
      resp_q  <= RSP_ABSENT;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else if (resp_q == RSP_GO) begin
      cnt_q   <= cnt_nxt;
      resp_q  <= (cnt_nxt == len) ? RSP_LAST : RSP_GO;
      first_q <= 1'b0;
    end else begin
      resp_q  <= RSP_ABSENT;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cop_follower.sv
module cop_follower
  import cpf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ID_W    = 4,
  parameter int LEN_W   = 4,
  parameter int ID_LSB  = 8,
  parameter int CLS_W   = 3,
  parameter int CLS_LSB = 25,
  parameter int CLS_VAL = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_n,
  input  logic [DATA_W-1:0] instr,
  input  logic [ID_W-1:0]   cp_id,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              pass,
  input  logic              cancel,
  output logic [1:0]        dec_resp,
  output logic [1:0]        exe_resp
);
  logic adv;
  logic dec_match;
  rsp_e dec_rsp;
  rsp_e exe_rsp;

  assign adv = ~adv_n;

  cpf_decode #(
    .DATA_W(DATA_W), .ID_W(ID_W), .ID_LSB(ID_LSB),
    .CLS_W(CLS_W), .CLS_LSB(CLS_LSB), .CLS_VAL(CLS_VAL)
  ) u_dec (
    .clk(clk), .rst(rst), .adv(adv), .hold(cancel),
    .instr(instr), .cp_id(cp_id),
    .match_q(dec_match), .resp_q(dec_rsp)
  );

  cpf_execute #(.LEN_W(LEN_W)) u_exe (
    .clk(clk), .rst(rst), .adv(adv), .cancel(cancel), .pass(pass),
    .dec_match(dec_match), .len(xfer_len), .resp_q(exe_rsp)
  );

  assign dec_resp = dec_rsp;
  assign exe_resp = exe_rsp;
endmodule

// File: rtl/cpf_checker.sv
module cpf_checker (
  input logic       clk,
  input logic       rst,
  input logic       adv_n,
  input logic       pass,
  input logic       cancel,
  input logic [1:0] dec_resp,
  input logic [1:0] exe_resp
);
  localparam logic [1:0] C_ABSENT = 2'b00;
  localparam logic [1:0] C_WAIT   = 2'b01;
  localparam logic [1:0] C_LAST   = 2'b11;

  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst_d && !rst) begin
      AST_RESET_ABSENT: assert (dec_resp == C_ABSENT && exe_resp == C_ABSENT); // R1
    end
  end

  AST_DEC_NEVER_LAST: assert property (@(posedge clk) disable iff (rst)
    dec_resp != C_LAST && dec_resp != C_WAIT); // R2

  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    adv_n |=> $stable(dec_resp)); // R3

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    (exe_resp == C_LAST && adv_n && !cancel) |=> exe_resp == C_ABSENT); // R6

  AST_ABSENT_STAYS: assert property (@(posedge clk) disable iff (rst)
    (exe_resp == C_ABSENT && adv_n) |=> exe_resp == C_ABSENT); // R6

  AST_EXE_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
    exe_resp != C_WAIT); // R5

  AST_PASS_DROP: assert property (@(posedge clk) disable iff (rst)
    ($past(!adv_n && !cancel) && adv_n && !pass) |=> exe_resp == C_ABSENT); // R7

  AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cancel |=> exe_resp == C_ABSENT); // R9

  AST_CANCEL_KEEPS_DEC: assert property (@(posedge clk) disable iff (rst)
    cancel |=> $stable(dec_resp)); // R10
endmodule

bind cop_follower cpf_checker u_chk (
  .clk(clk), .rst(rst), .adv_n(adv_n), .pass(pass), .cancel(cancel),
  .dec_resp(dec_resp), .exe_resp(exe_resp)
);

// File: tb/tb_cop_follower.sv
module tb_cop_follower;
  localparam logic [1:0] ABS = 2'b00, GO = 2'b10, LST = 2'b11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_n = 1'b1;
  logic [31:0] instr = '0;
  logic [3:0]  cp_id = 4'd5;
  logic [3:0]  xfer_len = '0;
  logic        pass = 1'b1;
  logic        cancel = 1'b0;
  logic [1:0]  dec_resp, exe_resp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cop_follower dut (
    .clk(clk), .rst(rst), .adv_n(adv_n), .instr(instr), .cp_id(cp_id),
    .xfer_len(xfer_len), .pass(pass), .cancel(cancel),
    .dec_resp(dec_resp), .exe_resp(exe_resp)
  );

  function automatic logic [31:0] mk(input logic [2:0] cls, input logic [3:0] id);
    return {4'h0, cls, 13'h0, id, 8'h00};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic [1:0] got, input logic [1:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic advance(input logic [31:0] w);
    adv_n = 1'b0;
    instr = w;
    tick();
    adv_n = 1'b1;
    instr = 32'hFFFF_FFFF;
  endtask

  // Expect L GO cycles then one LAST, then ABSENT; cycle 0 already visible.
  task automatic run_seq(input int L, input string req);
    for (int i = 0; i <= L; i++) begin
      chk(exe_resp, (i == L) ? LST : GO, req);
      tick();
    end
    chk(exe_resp, ABS, "R6");
    tick();
    chk(exe_resp, ABS, "R6");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    chk(dec_resp, ABS, "R1");
    chk(exe_resp, ABS, "R1");

    // R2: sweep class and coprocessor number against cp_id = 5.
    for (int c = 0; c < 8; c++) begin
      for (int id = 0; id < 16; id++) begin
        advance(mk(3'(c), 4'(id)));
        chk(dec_resp, (c == 6 && id == 5) ? GO : ABS, "R2");
      end
    end

    // R3: decode holds while adv_n is high.
    advance(mk(3'd6, 4'd5));
    instr = mk(3'd0, 4'd0);
    tick();
    chk(dec_resp, GO, "R3");
    advance(mk(3'd1, 4'd5));
    instr = mk(3'd6, 4'd5);
    tick();
    chk(dec_resp, ABS, "R3");

    // R4: non-matching decode entry gives ABSENT in execute.
    advance(mk(3'd6, 4'd5));
    chk(exe_resp, ABS, "R4");
    tick(); tick();

    // R4/R5: every length with a matching instruction.
    for (int L = 0; L < 16; L++) begin
      xfer_len = 4'(L);
      advance(mk(3'd6, 4'd5));
      advance(mk(3'd0, 4'd0));
      chk(exe_resp, (L == 0) ? LST : GO, "R4");
      run_seq(L, "R5");
    end

    // R7: pass low in first execute cycle drops the instruction.
    for (int L = 0; L < 4; L += 3) begin
      xfer_len = 4'(L);
      advance(mk(3'd6, 4'd5));
      advance(mk(3'd0, 4'd0));
      pass = 1'b0;
      tick();
      pass = 1'b1;
      chk(exe_resp, ABS, "R7");
      tick();
      chk(exe_resp, ABS, "R7");
    end

    // R8: pass low after the first cycle is ignored.
    xfer_len = 4'd5;
    advance(mk(3'd6, 4'd5));
    advance(mk(3'd0, 4'd0));
    chk(exe_resp, GO, "R8");
    tick();
    pass = 1'b0;
    for (int i = 1; i <= 5; i++) begin
      chk(exe_resp, (i == 5) ? LST : GO, "R8");
      tick();
    end
    pass = 1'b1;
    chk(exe_resp, ABS, "R8");

    // R9: cancel mid-transfer, decode kept, next instruction full length.
    xfer_len = 4'd7;
    advance(mk(3'd6, 4'd5));
    advance(mk(3'd6, 4'd5));
    tick(); tick();
    chk(exe_resp, GO, "R9");
    cancel = 1'b1;
    tick();
    cancel = 1'b0;
    chk(exe_resp, ABS, "R9");
    chk(dec_resp, GO, "R9");
    tick();
    chk(exe_resp, ABS, "R9");
    advance(mk(3'd0, 4'd0));
    run_seq(7, "R9");

    // R10: cancel together with an advance leaves decode unchanged.
    advance(mk(3'd6, 4'd5));
    chk(dec_resp, GO, "R10");
    cancel = 1'b1;
    adv_n = 1'b0;
    instr = mk(3'd0, 4'd0);
    tick();
    cancel = 1'b0;
    adv_n = 1'b1;
    chk(dec_resp, GO, "R10");
    chk(exe_resp, ABS, "R10");

    // R1: reset in the middle of a transfer.
    xfer_len = 4'd4;
    advance(mk(3'd0, 4'd0));
    chk(exe_resp, GO, "R4");
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk(dec_resp, ABS, "R1");
    chk(exe_resp, ABS, "R1");

    done = 1'b1;
    finish_run();
  end
endmodule